// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage Pipeline

This block is the control slice of an in-order pipeline with fetch, decode, execute, memory and write-back stages. It keeps a control token for each stage: an occupancy bit, the instruction address and three write-enable bits (register file, memory, condition codes). It also keeps a fault cause that travels with the instruction. Decode can flag an illegal opcode, the ALU can flag an arithmetic fault and the memory port can flag a page fault. Each flag is attached to the instruction that raised it. No action is taken until that instruction reaches the boundary between the memory and write-back stages.

At that boundary a faulting instruction is dropped, so it can be retried later. Every younger instruction in fetch, decode, execute and memory is turned into a bubble in the same clock. Fetch is sent to a fixed handler address, the cause code and restart address are latched, and a supervisor flag is raised. An external interrupt request is handled the same way, with two differences: the instruction in the memory stage is allowed to finish, and the restart address is the oldest instruction that was squashed. A return strobe, accepted only while the supervisor flag is set, squashes everything in flight, resumes fetch at the saved address and clears the flag.

Top module: `precise_trap_ctrl`

## Requirements
- R1: After reset the fetch address is RESET_PC, the supervisor flag is 0, the saved cause and saved address are 0, no trap is signalled, and no memory or write-back activity appears.
- R2: With no faults, the fetch address advances by INSN_BYTES each cycle. Each fetched instruction reaches write-back four cycles after it enters fetch, carrying its own address.
- R3: On a trap cycle, every instruction younger than the trapping point (fetch, decode and execute, plus the memory-stage instruction when it is the one faulting) becomes a bubble. None of them ever retires.
- R4: A memory-stage instruction whose page-fault input is high does not drive the memory write output in that same cycle, and it does not retire.
- R5: Cause codes are 1 for an illegal opcode flagged in decode, 2 for an arithmetic fault flagged in execute, 3 for a page fault flagged in memory and 4 for an external interrupt. For codes 1 to 3 the saved address is the faulting instruction's own address.
- R6: A trap pulses the trap output for one cycle. On the next cycle the fetch address is HANDLER_PC and the supervisor flag is 1. The first handler instruction retires four cycles later.
- R7: While the supervisor flag is 1, the return strobe squashes every instruction in fetch through memory, resumes fetch at the saved address and clears the flag. While the flag is 0 the strobe has no effect.
- R8: The saved cause and saved address change only on a trap cycle.
- R9: When several in-flight instructions carry faults, the oldest one's cause and address are saved. This holds even when a younger instruction raised its fault on an earlier cycle.
- R10: An interrupt request is taken only while the supervisor flag is 0 and no fault sits in the memory stage. The memory-stage instruction completes. The saved address is that of the oldest occupied stage among execute, decode and fetch, or the current fetch address if all three are empty.
- R11: The decode control input gives the write bits of the instruction in decode: bit 0 register write, bit 1 memory write, bit 2 condition-code write. An instruction that faults has all three bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| id_ctrl_i | input | 3 | Write bits of the instruction in decode (bit 0 register, bit 1 memory, bit 2 condition codes) |
| id_illegal_i | input | 1 | Decode found an illegal opcode |
| ex_arith_i | input | 1 | ALU reports an arithmetic fault |
| mem_fault_i | input | 1 | Memory port reports a page fault |
| irq_i | input | 1 | External interrupt request |
| eret_i | input | 1 | Return-from-handler strobe |
| fetch_pc_o | output | XLEN | Address being fetched |
| priv_o | output | 1 | Supervisor flag |
| trap_o | output | 1 | A trap is taken this cycle |
| cause_o | output | 3 | Saved cause code |
| epc_o | output | XLEN | Saved restart address |
| mem_we_o | output | 1 | Memory write permitted for the memory-stage instruction |
| wb_valid_o | output | 1 | An instruction is retiring |
| wb_pc_o | output | XLEN | Address of the retiring instruction |
| wb_rf_we_o | output | 1 | Register write of the retiring instruction |
| wb_cc_we_o | output | 1 | Condition-code write of the retiring instruction |

## Verification
The properties assume that the fault inputs describe only the instruction currently in the matching stage. They also assume that the return strobe is issued only to leave a handler, so that its restart address is the one latched by the previous trap. The directed scenarios raise each fault flag for exactly one cycle, at the cycle when the instruction of interest is known to occupy that stage. Interrupt and return strobes are released once the expected trap or redirect has been observed. Fault sources are combined only in the orderings that the priority requirement describes.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int NSTAGE = 5;
    localparam int S_IF   = 0;
    localparam int S_ID   = 1;
    localparam int S_EX   = 2;
    localparam int S_MEM  = 3;
    localparam int S_WB   = 4;

    localparam int CTL_W  = 3;
    localparam int WR_RF  = 0;
    localparam int WR_MEM = 1;
    localparam int WR_CC  = 2;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_ILLEGAL = 3'd1,
        CAUSE_ARITH   = 3'd2,
        CAUSE_PAGE    = 3'd3,
        CAUSE_IRQ     = 3'd4
    } cause_e;

    typedef struct packed {
        logic             valid;
        logic [CTL_W-1:0] wr;
        cause_e           cause;
    } ctl_t;

    localparam ctl_t CTL_BUBBLE = '{valid: 1'b0, wr: '0, cause: CAUSE_NONE};

endpackage

// File: rtl/ptc_pipe.sv
module ptc_pipe
    import ptc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [XLEN-1:0]  fetch_pc_i,
    input  logic [CTL_W-1:0] id_ctrl_i,
    input  logic             id_illegal_i,
    input  logic             ex_arith_i,
    input  logic             kill_front_i,
    input  logic             kill_mem_i,
    output logic [S_MEM:0]   stage_valid_o,
    output logic [XLEN-1:0]  if_pc_o,
    output logic [XLEN-1:0]  id_pc_o,
    output logic [XLEN-1:0]  ex_pc_o,
    output logic [XLEN-1:0]  mem_pc_o,
    output logic             mem_wr_o,
    output cause_e           mem_cause_o,
    output logic             wb_valid_o,
    output logic [XLEN-1:0]  wb_pc_o,
    output logic             wb_rf_o,
    output logic             wb_cc_o
);

    typedef struct packed {
        ctl_t [NSTAGE-1:0]            ctl;
        logic [NSTAGE-1:0][XLEN-1:0]  pc;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;

        // new fetch slot
        pipe_d.ctl[S_IF] = '{valid: 1'b1, wr: '0, cause: CAUSE_NONE};
        pipe_d.pc[S_IF]  = fetch_pc_i;

        // shift tokens one stage down
        for (int s = S_ID; s < NSTAGE; s++) begin
            pipe_d.ctl[s] = pipe_q.ctl[s-1];
            pipe_d.pc[s]  = pipe_q.pc[s-1];
        end

        // decode attaches the write bits or an illegal-opcode cause
        pipe_d.ctl[S_EX].wr = pipe_q.ctl[S_ID].valid ? id_ctrl_i : '0;
        if (pipe_q.ctl[S_ID].valid && id_illegal_i) begin
            pipe_d.ctl[S_EX].cause = CAUSE_ILLEGAL;
            pipe_d.ctl[S_EX].wr    = '0;
        end

        // execute adds an arithmetic cause unless one is already carried
        if (pipe_q.ctl[S_EX].valid && ex_arith_i &&
            pipe_q.ctl[S_EX].cause == CAUSE_NONE) begin
            pipe_d.ctl[S_MEM].cause = CAUSE_ARITH;
            pipe_d.ctl[S_MEM].wr    = '0;
        end

        // squash everything younger than the commit point
        if (kill_front_i) begin
            for (int s = S_IF; s <= S_MEM; s++) begin
                pipe_d.ctl[s] = CTL_BUBBLE;
            end
        end

        // the memory-stage instruction does not retire
        if (kill_mem_i) begin
            pipe_d.ctl[S_WB] = CTL_BUBBLE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar g = S_IF; g <= S_MEM; g++) begin : g_live
        assign stage_valid_o[g] = pipe_q.ctl[g].valid;
    end

    assign if_pc_o     = pipe_q.pc[S_IF];
    assign id_pc_o     = pipe_q.pc[S_ID];
    assign ex_pc_o     = pipe_q.pc[S_EX];
    assign mem_pc_o    = pipe_q.pc[S_MEM];
    assign mem_wr_o    = pipe_q.ctl[S_MEM].wr[WR_MEM];
    assign mem_cause_o = pipe_q.ctl[S_MEM].cause;
    assign wb_valid_o  = pipe_q.ctl[S_WB].valid;
    assign wb_pc_o     = pipe_q.pc[S_WB];
    assign wb_rf_o     = pipe_q.ctl[S_WB].valid & pipe_q.ctl[S_WB].wr[WR_RF];
    assign wb_cc_o     = pipe_q.ctl[S_WB].valid & pipe_q.ctl[S_WB].wr[WR_CC];

endmodule

// File: rtl/ptc_trap_sel.sv
module ptc_trap_sel
    import ptc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [S_MEM:0]  stage_valid_i,
    input  logic [XLEN-1:0] if_pc_i,
    input  logic [XLEN-1:0] id_pc_i,
    input  logic [XLEN-1:0] ex_pc_i,
    input  logic [XLEN-1:0] mem_pc_i,
    input  logic [XLEN-1:0] fetch_pc_i,
    input  logic            mem_wr_i,
    input  cause_e          mem_cause_i,
    input  logic            mem_fault_i,
    input  logic            irq_i,
    input  logic            eret_i,
    input  logic            priv_i,
    output logic            trap_o,
    output cause_e          cause_o,
    output logic [XLEN-1:0] restart_pc_o,
    output logic            kill_front_o,
    output logic            kill_mem_o,
    output logic            eret_fire_o,
    output logic            mem_we_o
);

    cause_e     eff_cause;
    logic       take_exc;
    logic       take_irq;
    logic       eret_fire;

    always_comb begin
        eret_fire = eret_i & priv_i;

        // cause carried by the commit-point instruction, older causes first
        eff_cause = CAUSE_NONE;
        if (stage_valid_i[S_MEM]) begin
            if (mem_cause_i != CAUSE_NONE) begin
                eff_cause = mem_cause_i;
            end else if (mem_fault_i) begin
                eff_cause = CAUSE_PAGE;
            end
        end

        take_exc = !eret_fire && (eff_cause != CAUSE_NONE);
        take_irq = !eret_fire && !take_exc && irq_i && !priv_i;

        trap_o  = take_exc | take_irq;
        cause_o = take_exc ? eff_cause : (take_irq ? CAUSE_IRQ : CAUSE_NONE);

        // restart at the faulting one, or at the oldest squashed one
        if (take_exc) begin
            restart_pc_o = mem_pc_i;
        end else if (stage_valid_i[S_EX]) begin
            restart_pc_o = ex_pc_i;
        end else if (stage_valid_i[S_ID]) begin
            restart_pc_o = id_pc_i;
        end else if (stage_valid_i[S_IF]) begin
            restart_pc_o = if_pc_i;
        end else begin
            restart_pc_o = fetch_pc_i;
        end

        kill_front_o = trap_o | eret_fire;
        kill_mem_o   = take_exc | eret_fire;
        eret_fire_o  = eret_fire;
        mem_we_o     = stage_valid_i[S_MEM] & mem_wr_i &
                       (eff_cause == CAUSE_NONE) & !eret_fire;
    end

endmodule

// File: rtl/ptc_mode_regs.sv
module ptc_mode_regs
    import ptc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_PC   = '0,
    parameter logic [XLEN-1:0] HANDLER_PC = 'h100,
    parameter int              INSN_BYTES = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            trap_i,
    input  cause_e          cause_i,
    input  logic [XLEN-1:0] restart_pc_i,
    input  logic            eret_fire_i,
    output logic [XLEN-1:0] fetch_pc_o,
    output logic            priv_o,
    output cause_e          cause_o,
    output logic [XLEN-1:0] epc_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic [XLEN-1:0] fetch_pc;
        logic            priv;
        cause_e          cause;
        logic [XLEN-1:0] epc;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d          = mode_q;
        mode_d.fetch_pc = mode_q.fetch_pc + STEP;
        if (trap_i) begin
            mode_d.fetch_pc = HANDLER_PC;
            mode_d.priv     = 1'b1;
            mode_d.cause    = cause_i;
            mode_d.epc      = restart_pc_i;
        end else if (eret_fire_i) begin
            mode_d.fetch_pc = mode_q.epc;
            mode_d.priv     = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= '{fetch_pc: RESET_PC, priv: 1'b0, cause: CAUSE_NONE, epc: '0};
        end else begin
            mode_q <= mode_d;
        end
    end

    assign fetch_pc_o = mode_q.fetch_pc;
    assign priv_o     = mode_q.priv;
    assign cause_o    = mode_q.cause;
    assign epc_o      = mode_q.epc;

endmodule

// File: rtl/precise_trap_ctrl.sv
module precise_trap_ctrl
    import ptc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_PC   = '0,
    parameter logic [XLEN-1:0] HANDLER_PC = 'h100,
    parameter int              INSN_BYTES = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [2:0]      id_ctrl_i,
    input  logic            id_illegal_i,
    input  logic            ex_arith_i,
    input  logic            mem_fault_i,
    input  logic            irq_i,
    input  logic            eret_i,
    output logic [XLEN-1:0] fetch_pc_o,
    output logic            priv_o,
    output logic            trap_o,
    output logic [2:0]      cause_o,
    output logic [XLEN-1:0] epc_o,
    output logic            mem_we_o,
    output logic            wb_valid_o,
    output logic [XLEN-1:0] wb_pc_o,
    output logic            wb_rf_we_o,
    output logic            wb_cc_we_o
);

    logic [S_MEM:0]  stage_valid;
    logic [XLEN-1:0] if_pc, id_pc, ex_pc, mem_pc;
    logic            mem_wr;
    cause_e          mem_cause;
    logic            trap;
    cause_e          trap_cause;
    logic [XLEN-1:0] restart_pc;
    logic            kill_front, kill_mem, eret_fire;
    cause_e          saved_cause;

    ptc_pipe #(.XLEN(XLEN)) u_pipe (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .fetch_pc_i    (fetch_pc_o),
        .id_ctrl_i     (id_ctrl_i),
        .id_illegal_i  (id_illegal_i),
        .ex_arith_i    (ex_arith_i),
        .kill_front_i  (kill_front),
        .kill_mem_i    (kill_mem),
        .stage_valid_o (stage_valid),
        .if_pc_o       (if_pc),
        .id_pc_o       (id_pc),
        .ex_pc_o       (ex_pc),
        .mem_pc_o      (mem_pc),
        .mem_wr_o      (mem_wr),
        .mem_cause_o   (mem_cause),
        .wb_valid_o    (wb_valid_o),
        .wb_pc_o       (wb_pc_o),
        .wb_rf_o       (wb_rf_we_o),
        .wb_cc_o       (wb_cc_we_o)
    );

    ptc_trap_sel #(.XLEN(XLEN)) u_sel (
        .stage_valid_i (stage_valid),
        .if_pc_i       (if_pc),
        .id_pc_i       (id_pc),
        .ex_pc_i       (ex_pc),
        .mem_pc_i      (mem_pc),
        .fetch_pc_i    (fetch_pc_o),
        .mem_wr_i      (mem_wr),
        .mem_cause_i   (mem_cause),
        .mem_fault_i   (mem_fault_i),
        .irq_i         (irq_i),
        .eret_i        (eret_i),
        .priv_i        (priv_o),
        .trap_o        (trap),
        .cause_o       (trap_cause),
        .restart_pc_o  (restart_pc),
        .kill_front_o  (kill_front),
        .kill_mem_o    (kill_mem),
        .eret_fire_o   (eret_fire),
        .mem_we_o      (mem_we_o)
    );

    ptc_mode_regs #(
        .XLEN       (XLEN),
        .RESET_PC   (RESET_PC),
        .HANDLER_PC (HANDLER_PC),
        .INSN_BYTES (INSN_BYTES)
    ) u_mode (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .trap_i       (trap),
        .cause_i      (trap_cause),
        .restart_pc_i (restart_pc),
        .eret_fire_i  (eret_fire),
        .fetch_pc_o   (fetch_pc_o),
        .priv_o       (priv_o),
        .cause_o      (saved_cause),
        .epc_o        (epc_o)
    );

    assign trap_o  = trap;
    assign cause_o = saved_cause;

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] HANDLER_PC = 'h100
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            trap_i,
    input logic            priv_i,
    input logic [2:0]      cause_i,
    input logic [XLEN-1:0] epc_i,
    input logic [XLEN-1:0] fetch_pc_i,
    input logic            eret_i,
    input logic            mem_fault_i,
    input logic            mem_we_i,
    input logic [3:0]      stage_valid_i
);

    // R6: trap enters supervisor mode at the handler address
    p_trap_enters_handler_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (priv_i && fetch_pc_i == HANDLER_PC));

    // R4: no memory write for a page-faulting access
    p_no_write_on_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_fault_i |-> !mem_we_i);

    // R3: decode, execute and memory hold bubbles right after a trap
    p_younger_squashed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (stage_valid_i[3:1] == 3'b000));

    // R8: saved state only moves on a trap
    p_saved_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_i |=> ($stable(cause_i) && $stable(epc_i)));

    // R5: a trap always records a non-null cause
    p_cause_nonnull_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (cause_i != 3'd0));

    // R7: accepted return resumes at the saved address in user mode
    p_return_resumes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eret_i && priv_i) |=> (!priv_i && fetch_pc_i == $past(epc_i)));

endmodule

bind precise_trap_ctrl ptc_checker #(
    .XLEN       (XLEN),
    .HANDLER_PC (HANDLER_PC)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trap_i        (trap_o),
    .priv_i        (priv_o),
    .cause_i       (cause_o),
    .epc_i         (epc_o),
    .fetch_pc_i    (fetch_pc_o),
    .eret_i        (eret_i),
    .mem_fault_i   (mem_fault_i),
    .mem_we_i      (mem_we_o),
    .stage_valid_i (stage_valid)
);

// File: tb/sim_precise_trap_ctrl.sv
module sim_precise_trap_ctrl;

    localparam logic [31:0] HANDLER = 32'h100;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [2:0]  id_ctrl = 3'b111;
    logic        id_illegal = 1'b0;
    logic        ex_arith = 1'b0;
    logic        mem_fault = 1'b0;
    logic        irq = 1'b0;
    logic        eret = 1'b0;
    logic [31:0] fetch_pc, epc, wb_pc;
    logic        priv, trap, mem_we, wb_valid, wb_rf_we, wb_cc_we;
    logic [2:0]  cause;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    precise_trap_ctrl u0 (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .id_ctrl_i    (id_ctrl),
        .id_illegal_i (id_illegal),
        .ex_arith_i   (ex_arith),
        .mem_fault_i  (mem_fault),
        .irq_i        (irq),
        .eret_i       (eret),
        .fetch_pc_o   (fetch_pc),
        .priv_o       (priv),
        .trap_o       (trap),
        .cause_o      (cause),
        .epc_o        (epc),
        .mem_we_o     (mem_we),
        .wb_valid_o   (wb_valid),
        .wb_pc_o      (wb_pc),
        .wb_rf_we_o   (wb_rf_we),
        .wb_cc_we_o   (wb_cc_we)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // leaves the bench at a falling edge with zero steps taken
    task automatic do_reset();
        rst_ni = 1'b0; id_ctrl = 3'b111; id_illegal = 1'b0; ex_arith = 1'b0;
        mem_fault = 1'b0; irq = 1'b0; eret = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 fetch", fetch_pc, 32'h0);
        check("R1 priv", {31'b0, priv}, 32'h0);
        check("R1 cause", {29'b0, cause}, 32'h0);
        check("R1 epc", epc, 32'h0);
        check("R1 trap", {31'b0, trap}, 32'h0);
        check("R1 wb_valid", {31'b0, wb_valid}, 32'h0);
        check("R1 mem_we", {31'b0, mem_we}, 32'h0);
    endtask

    task automatic t_flow();
        do_reset();
        step(2);
        id_ctrl = 3'b100;               // pc 0 in decode: cc only
        step(1);
        id_ctrl = 3'b111;
        step(1);                        // pc 0 in memory
        check("R11 mem_we off", {31'b0, mem_we}, 32'h0);
        step(1);
        check("R2 retire pc0", {31'b0, wb_valid}, 32'h1);
        check("R2 wb_pc0", wb_pc, 32'h0);
        check("R11 rf bit", {31'b0, wb_rf_we}, 32'h0);
        check("R11 cc bit", {31'b0, wb_cc_we}, 32'h1);
        check("R11 mem_we on", {31'b0, mem_we}, 32'h1);
        step(1);
        check("R2 wb_pc4", wb_pc, 32'h4);
        check("R2 fetch advance", fetch_pc, 32'd24);
    endtask

    task automatic t_illegal();
        do_reset();
        step(4);
        id_illegal = 1'b1;              // pc 8 in decode
        step(1);
        id_illegal = 1'b0;
        step(1);                        // pc 8 at commit point
        check("R6 trap pulse", {31'b0, trap}, 32'h1);
        check("R11 faulting bits cleared", {31'b0, mem_we}, 32'h0);
        check("R3 older retires", wb_pc, 32'h4);
        step(1);
        check("R5 illegal cause", {29'b0, cause}, 32'd1);
        check("R5 epc", epc, 32'h8);
        check("R6 priv", {31'b0, priv}, 32'h1);
        check("R6 fetch handler", fetch_pc, HANDLER);
        check("R6 trap single", {31'b0, trap}, 32'h0);
        check("R3 faulting dropped", {31'b0, wb_valid}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            step(1);
            check("R3 younger never retire", {31'b0, wb_valid}, 32'h0);
        end
        step(1);
        check("R6 handler retires", wb_pc, HANDLER);
        check("R8 epc held", epc, 32'h8);
    endtask

    task automatic t_arith();
        do_reset();
        step(5);
        ex_arith = 1'b1;                // pc 8 in execute
        step(1);
        ex_arith = 1'b0;
        check("R5 arith trap", {31'b0, trap}, 32'h1);
        step(1);
        check("R5 arith cause", {29'b0, cause}, 32'd2);
        check("R5 arith epc", epc, 32'h8);
    endtask

    task automatic t_page();
        do_reset();
        step(6);
        mem_fault = 1'b1;               // pc 8 in memory
        #1;
        check("R4 no write", {31'b0, mem_we}, 32'h0);
        check("R4 trap", {31'b0, trap}, 32'h1);
        step(1);
        mem_fault = 1'b0;
        check("R5 page cause", {29'b0, cause}, 32'd3);
        check("R5 page epc", epc, 32'h8);
        check("R4 not retired", {31'b0, wb_valid}, 32'h0);
    endtask

    task automatic t_oldest();
        do_reset();
        step(5);
        id_illegal = 1'b1;              // younger pc 12 faults first
        step(1);
        id_illegal = 1'b0;
        mem_fault = 1'b1;               // older pc 8 faults later
        step(1);
        mem_fault = 1'b0;
        check("R9 older cause", {29'b0, cause}, 32'd3);
        check("R9 older epc", epc, 32'h8);
        do_reset();
        step(5);
        ex_arith = 1'b1;                // pc 8 in execute
        id_illegal = 1'b1;              // pc 12 in decode
        step(1);
        ex_arith = 1'b0; id_illegal = 1'b0;
        step(1);
        check("R9 same-cycle cause", {29'b0, cause}, 32'd2);
        check("R9 same-cycle epc", epc, 32'h8);
    endtask

    task automatic t_irq();
        do_reset();
        step(7);
        irq = 1'b1;                     // pc 12 in memory, pc 16 in execute
        #1;
        check("R10 irq trap", {31'b0, trap}, 32'h1);
        check("R10 boundary writes", {31'b0, mem_we}, 32'h1);
        step(1);
        check("R10 irq cause", {29'b0, cause}, 32'd4);
        check("R10 irq epc", epc, 32'd16);
        check("R10 boundary retires", wb_pc, 32'd12);
        check("R10 masked in supervisor", {31'b0, trap}, 32'h0);
        step(1);
        irq = 1'b0;
        check("R8 cause held", {29'b0, cause}, 32'd4);
        do_reset();
        step(6);
        irq = 1'b1; mem_fault = 1'b1;
        step(1);
        irq = 1'b0; mem_fault = 1'b0;
        check("R10 fault beats irq", {29'b0, cause}, 32'd3);
    endtask

    task automatic t_eret();
        do_reset();
        step(7);
        irq = 1'b1;
        step(1);
        irq = 1'b0;
        step(2);
        eret = 1'b1;
        step(1);
        eret = 1'b0;
        check("R7 resume fetch", fetch_pc, 32'd16);
        check("R7 priv cleared", {31'b0, priv}, 32'h0);
        check("R8 epc after return", epc, 32'd16);
        irq = 1'b1;                     // pipe empty: restart at fetch address
        step(1);
        irq = 1'b0;
        check("R10 empty pipe epc", epc, 32'd16);
        check("R10 empty pipe priv", {31'b0, priv}, 32'h1);
        step(1);
        eret = 1'b1;
        step(1);
        eret = 1'b0;
        step(5);
        check("R7 resumed retires", wb_pc, 32'd16);
        check("R7 resumed valid", {31'b0, wb_valid}, 32'h1);
    endtask

    task automatic t_eret_user();
        do_reset();
        step(3);
        eret = 1'b1;
        step(1);
        eret = 1'b0;
        check("R7 ignored fetch", fetch_pc, 32'd16);
        check("R7 ignored priv", {31'b0, priv}, 32'h0);
        step(1);
        check("R7 ignored retire", wb_pc, 32'h0);
        check("R7 ignored valid", {31'b0, wb_valid}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_flow();
        t_illegal();
        t_arith();
        t_page();
        t_oldest();
        t_irq();
        t_eret();
        t_eret_user();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule